// File: doc/BRIEF.md
# Shared-Pin Serial Register Configuration Port

This block is the configuration slave of a mixed-signal device. It puts two serial protocols on three pins: a select pin, a clock pin and a data pin. After reset the port behaves as a 2-wire slave. In that mode the select pin is read as a static strap that supplies the lowest bit of the slave address. The first falling edge seen on the select pin switches the port to a write-only SPI slave, and it stays in SPI mode until the next reset. Either protocol ends in one internal write path. That path updates a byte-wide register file and announces each accepted write on a one-cycle strobe that carries the register address and data.

All pins are oversampled by the system clock through two-flop synchronizers. Edges and the 2-wire START and STOP conditions are detected on the synchronized copies. The data pin is open-drain: the port only ever asks for it to be pulled low, for acknowledges and for read data.

An SPI write is a fixed frame of three bytes, sent most significant bit first and sampled on the rising clock edge:
- a chip byte;
- a register address;
- the register data.

A 2-wire write carries the device byte, then a register pointer, then any number of data bytes, which all go to the pointed register. A 2-wire read returns the pointed register, repeated for every byte until the master answers with a not-acknowledge.

Top module: `dual_ctrl_port`

## Requirements
- R1: While reset is held, and on the cycle after reset is released, the port releases the data pin (ctl_dat_pull_low = 0) and keeps wr_strobe low. The port starts in 2-wire mode.
- R2: A falling edge on ce_pin switches the port to SPI mode until the next reset. In SPI mode the port never pulls the data pin low and ignores all 2-wire traffic.
- R3: In SPI mode, while ce_pin is low, a frame of 24 bits is sampled MSB first on rising ctl_clk_pin edges. If the first byte equals 0x20 (chip code 0010000 followed by a write bit of 0), the port pulses wr_strobe once. That pulse carries the second byte on wr_addr and the third byte on wr_data, and the value is stored in the register file.
- R4: An SPI frame whose first byte is not 0x20 causes no write. Bits after the 24th are ignored until ce_pin returns high.
- R5: In 2-wire mode the port acknowledges a device byte whose upper seven bits are 001000 followed by the current ce_pin level. It does this by pulling the data pin low during the ninth clock. Any other device byte gets no acknowledge, and the port ignores the data bytes that follow the unacknowledged device byte until the next START.
- R6: After a device byte with R/W = 0, the next byte is the register pointer. Every later byte is acknowledged and written to the pointed register, and each one gives one wr_strobe pulse.
- R7: After a device byte with R/W = 1, the port shifts out the pointed register MSB first on every byte. It keeps doing so while the master acknowledges, and stops at a not-acknowledge.
- R8: The register file covers addresses 0 to 52. Writes to 53 to 255 are acknowledged, give no wr_strobe and change nothing. Reads of those addresses return 0x00.
- R9: A START (data falling while the clock is high) restarts device-byte reception in any state. A STOP (data rising while the clock is high) ends the transaction and releases the pin. A byte cut short by a STOP writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_pin | input | 1 | Select pin: SPI chip select, or 2-wire address strap |
| ctl_clk_pin | input | 1 | Serial clock pin (SPI clock or 2-wire SCL) |
| ctl_dat_pin | input | 1 | Level of the shared data pin (SPI data in or 2-wire SDA) |
| ctl_dat_pull_low | output | 1 | Open-drain drive: 1 pulls the data pin low |
| wr_strobe | output | 1 | One-cycle pulse for each accepted register write |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data of the write |

## Verification
The bench checks the mode latch. A port that let 2-wire logic run after a select-pin fall would acknowledge later 2-wire traffic, and one that cleared the mode on select rising would lose SPI frames. It sends SPI frames with a wrong chip byte and with extra trailing bits. A decoder that skipped the chip check or kept counting would produce spurious or duplicate strobes, and the read-back after reset shows whether a discarded frame changed the register file. On the 2-wire side it covers the following:
- both address strap levels, where a wrong strap match would acknowledge the wrong device byte;
- a repeated START into a read, where a slave that missed the START would keep receiving;
- a STOP in mid-byte, where a partial byte would be written;
- out-of-range pointers, where a slave without the range check would raise a strobe or read back stale memory.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [6:0] SPI_CHIP_ID = 7'b0010000;
  localparam logic [5:0] TWI_ID_HI   = 6'b001000;

  typedef enum logic [2:0] {
    TW_IDLE,
    TW_RECV,
    TW_ACK,
    TW_SEND,
    TW_MACK
  } tw_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } tw_phase_t;
endpackage

// File: rtl/cfgp_pin_sync.sv
module cfgp_pin_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {(STAGES+1){RST_VAL[g]}};
      else     chain <= {chain[STAGES-1:0], pin[g]};
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/cfgp_spi_rx.sv
module cfgp_spi_rx
  import cfgp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cs_lvl,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int FRAME_BITS = 3 * BYTE_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] END_ID   = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] END_ADDR = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] END_DATA = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);
  localparam logic [BYTE_W-1:0] ID_BYTE = BYTE_W'({SPI_CHIP_ID, 1'b0});

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sh_nxt;
  logic              id_ok;
  logic [BYTE_W-1:0] addr_q;

  assign sh_nxt = {sh[BYTE_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; sh <= '0; id_ok <= 1'b0; addr_q <= '0;
      wr_req <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      if (cs_lvl || !en) begin
        cnt <= '0;
        id_ok <= 1'b0;
      end else if (sck_rise && cnt != FULL) begin
        sh  <= sh_nxt;
        cnt <= cnt + 1'b1;
        if (cnt == END_ID)   id_ok  <= (sh_nxt == ID_BYTE);
        if (cnt == END_ADDR) addr_q <= sh_nxt;
        if (cnt == END_DATA && id_ok) begin
          wr_req  <= 1'b1;
          wr_addr <= addr_q;
          wr_data <= sh_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/cfgp_twi_slave.sv
module cfgp_twi_slave
  import cfgp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ad0,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_low,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tw_state_t         state;
  tw_phase_t         phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              nack;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= TW_IDLE; phase <= PH_ADDR; cnt <= '0; sh <= '0;
      nack <= 1'b0; sda_low <= 1'b0; ptr <= '0;
      wr_req <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      if (scl_s && sda_fall) begin
        state <= TW_RECV; phase <= PH_ADDR; cnt <= '0; sda_low <= 1'b0;
      end else if (scl_s && sda_rise) begin
        state <= TW_IDLE; sda_low <= 1'b0;
      end else begin
        unique case (state)
          TW_RECV: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              unique case (phase)
                PH_ADDR: begin
                  if (sh[BYTE_W-1:1] == {TWI_ID_HI, ad0}) begin
                    sda_low <= 1'b1;
                    state   <= TW_ACK;
                    if (!sh[0]) phase <= PH_PTR;
                  end else begin
                    state <= TW_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr <= sh; sda_low <= 1'b1; state <= TW_ACK; phase <= PH_DATA;
                end
                default: begin
                  wr_req <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                  sda_low <= 1'b1; state <= TW_ACK;
                end
              endcase
            end
          end
          TW_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (phase == PH_ADDR) begin
                state   <= TW_SEND;
                sh      <= rd_byte;
                sda_low <= ~rd_byte[BYTE_W-1];
              end else begin
                state   <= TW_RECV;
                sda_low <= 1'b0;
              end
            end
          end
          TW_SEND: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_low <= 1'b0; state <= TW_MACK; cnt <= '0;
              end else begin
                sh      <= {sh[BYTE_W-2:0], 1'b0};
                sda_low <= ~sh[BYTE_W-2];
                cnt     <= cnt + 1'b1;
              end
            end
          end
          TW_MACK: begin
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              if (nack) state <= TW_IDLE;
              else begin
                state <= TW_SEND; sh <= rd_byte;
                sda_low <= ~rd_byte[BYTE_W-1]; cnt <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
  parameter int BYTE_W = 8,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dual_ctrl_port.sv
module dual_ctrl_port #(
  parameter int BYTE_W = 8,
  parameter int LAST_REG = 52,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_pin,
  input  logic              ctl_clk_pin,
  input  logic              ctl_dat_pin,
  output logic              ctl_dat_pull_low,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int IDX_W = $clog2(LAST_REG + 1);
  localparam logic [BYTE_W-1:0] LAST_A = BYTE_W'(LAST_REG);

  logic [2:0] p_lvl, p_rise, p_fall;
  logic ce_s, scl_s, sda_s;

  cfgp_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .pin({ctl_dat_pin, ctl_clk_pin, ce_pin}),
    .lvl(p_lvl), .rise(p_rise), .fall(p_fall)
  );
  assign ce_s  = p_lvl[0];
  assign scl_s = p_lvl[1];
  assign sda_s = p_lvl[2];

  logic unused_edges;
  assign unused_edges = p_rise[0];

  logic mode_spi;
  always_ff @(posedge clk) begin
    if (rst)            mode_spi <= 1'b0;
    else if (p_fall[0]) mode_spi <= 1'b1;
  end

  logic              spi_req;
  logic [BYTE_W-1:0] spi_addr, spi_data;
  cfgp_spi_rx #(.BYTE_W(BYTE_W)) u_spi (
    .clk(clk), .rst(rst), .en(mode_spi), .cs_lvl(ce_s),
    .sck_rise(p_rise[1]), .sdi(sda_s),
    .wr_req(spi_req), .wr_addr(spi_addr), .wr_data(spi_data)
  );

  logic              twi_req, twi_low;
  logic [BYTE_W-1:0] twi_addr, twi_data, twi_ptr, rd_byte, rd_q;
  cfgp_twi_slave #(.BYTE_W(BYTE_W)) u_twi (
    .clk(clk), .rst(rst), .en(!mode_spi), .ad0(ce_s),
    .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(p_rise[1]), .scl_fall(p_fall[1]),
    .sda_rise(p_rise[2]), .sda_fall(p_fall[2]),
    .rd_byte(rd_byte), .sda_low(twi_low), .ptr(twi_ptr),
    .wr_req(twi_req), .wr_addr(twi_addr), .wr_data(twi_data)
  );

  logic              req, in_range, we;
  logic [BYTE_W-1:0] req_addr, req_data;
  assign req      = mode_spi ? spi_req  : twi_req;
  assign req_addr = mode_spi ? spi_addr : twi_addr;
  assign req_data = mode_spi ? spi_data : twi_data;
  assign in_range = (req_addr <= LAST_A);
  assign we       = req && in_range;

  cfgp_regfile #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .we(we), .waddr(req_addr[IDX_W-1:0]), .wdata(req_data),
    .raddr(twi_ptr[IDX_W-1:0]), .rdata(rd_q)
  );

  logic rd_ok;
  always_ff @(posedge clk) begin
    if (rst) rd_ok <= 1'b0;
    else     rd_ok <= (twi_ptr <= LAST_A);
  end
  assign rd_byte = rd_ok ? rd_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_strobe <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_strobe <= we;
      if (we) begin
        wr_addr <= req_addr;
        wr_data <= req_data;
      end
    end
  end

  assign ctl_dat_pull_low = twi_low && !mode_spi;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int BYTE_W = 8,
  parameter int LAST_REG = 52
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_spi,
  input logic              scl_s,
  input logic              ctl_dat_pull_low,
  input logic              wr_strobe,
  input logic [BYTE_W-1:0] wr_addr
);
  localparam logic [BYTE_W-1:0] LAST_A = BYTE_W'(LAST_REG);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ctl_dat_pull_low && !wr_strobe && !mode_spi));

  assert_spi_releases_pin_R2: assert property (@(posedge clk) disable iff (rst)
    mode_spi |-> !ctl_dat_pull_low);

  assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    mode_spi |=> mode_spi);

  assert_drive_while_clk_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_dat_pull_low) |-> !scl_s);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  assert_strobe_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> (wr_addr <= LAST_A));
endmodule

bind dual_ctrl_port cfgp_checker #(.BYTE_W(BYTE_W), .LAST_REG(LAST_REG)) u_chk (
  .clk(clk), .rst(rst), .mode_spi(mode_spi), .scl_s(scl_s),
  .ctl_dat_pull_low(ctl_dat_pull_low), .wr_strobe(wr_strobe), .wr_addr(wr_addr)
);

// File: tb/dual_ctrl_port_test.sv
module dual_ctrl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic pull_low, wr_strobe;
  logic [7:0] wr_addr, wr_data;
  wire sda_bus = m_sda & ~pull_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_ctrl_port uut (
    .clk(clk), .rst(rst), .ce_pin(ce), .ctl_clk_pin(m_scl), .ctl_dat_pin(sda_bus),
    .ctl_dat_pull_low(pull_low), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0, fails = 0, stb_cnt = 0;
  logic [7:0] last_a, last_d;
  bit done = 0;

  always @(posedge clk) if (!rst && wr_strobe) begin
    stb_cnt <= stb_cnt + 1; last_a <= wr_addr; last_d <= wr_data;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset(input logic lvl);
    rst = 1'b1; ce = lvl; m_scl = 1'b1; m_sda = 1'b1;
    hw(4);
    check("R1", pull_low, 0);
    check("R1", wr_strobe, 0);
    rst = 1'b0;
    hw(1);
    check("R1", pull_low, 0);
    check("R1", wr_strobe, 0);
    hw(4);
  endtask

  task automatic tw_start;
    m_sda = 1'b1; hw(W); m_scl = 1'b1; hw(W); m_sda = 1'b0; hw(W); m_scl = 1'b0; hw(W);
  endtask

  task automatic tw_stop;
    m_sda = 1'b0; hw(W); m_scl = 1'b1; hw(W); m_sda = 1'b1; hw(W);
  endtask

  task automatic tw_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(W); m_scl = 1'b1; hw(W); m_scl = 1'b0;
    end
    m_sda = 1'b1; hw(W); m_scl = 1'b1; hw(W); ack = sda_bus; m_scl = 1'b0; hw(2);
  endtask

  task automatic tw_rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(W); m_scl = 1'b1; hw(W); b[i] = sda_bus; m_scl = 1'b0;
    end
    hw(2); m_sda = ~mack; hw(W); m_scl = 1'b1; hw(W); m_scl = 1'b0; hw(2); m_sda = 1'b1;
  endtask

  task automatic tw_write(input logic [7:0] dev, input logic [7:0] ptr, input logic [7:0] d,
                          input string req);
    logic a;
    tw_start;
    tw_wbyte(dev, a); check(req, a, 0);
    tw_wbyte(ptr, a); check(req, a, 0);
    tw_wbyte(d, a);   check(req, a, 0);
    tw_stop;
  endtask

  task automatic tw_read(input logic [7:0] dev, input logic [7:0] ptr, output logic [7:0] d);
    logic a;
    tw_start;
    tw_wbyte(dev, a);
    tw_wbyte(ptr, a);
    tw_start;
    tw_wbyte(dev | 8'h01, a);
    tw_rbyte(1'b0, d);
    tw_stop;
  endtask

  task automatic spi_send(input logic [31:0] bits, input int n);
    m_scl = 1'b0; hw(W); ce = 1'b0; hw(W);
    for (int i = n - 1; i >= 0; i--) begin
      m_scl = 1'b0; m_sda = bits[i]; hw(W); m_scl = 1'b1; hw(W);
    end
    m_scl = 1'b0; hw(W); ce = 1'b1; hw(2*W);
  endtask

  task automatic t_twi_write;
    int s0 = stb_cnt;
    tw_write(8'h20, 8'h05, 8'hA5, "R6");
    check("R6", stb_cnt - s0, 1);
    check("R6", last_a, 8'h05);
    check("R6", last_d, 8'hA5);
  endtask

  task automatic t_twi_read;
    logic a; logic [7:0] d0, d1;
    tw_start;
    tw_wbyte(8'h20, a); tw_wbyte(8'h05, a);
    tw_start;
    tw_wbyte(8'h21, a); check("R7", a, 0);
    tw_rbyte(1'b1, d0); tw_rbyte(1'b0, d1);
    tw_stop;
    check("R7", d0, 8'hA5);
    check("R7", d1, 8'hA5);
    check("R7", pull_low, 0);
  endtask

  task automatic t_twi_bad_dev;
    logic a; int s0 = stb_cnt;
    tw_start;
    tw_wbyte(8'h22, a); check("R5", a, 1);
    tw_wbyte(8'h05, a); check("R5", a, 1);
    tw_wbyte(8'h33, a); check("R5", a, 1);
    tw_stop;
    check("R5", stb_cnt - s0, 0);
  endtask

  task automatic t_twi_multi;
    logic a; logic [7:0] d; int s0 = stb_cnt;
    tw_start;
    tw_wbyte(8'h20, a); tw_wbyte(8'h08, a);
    tw_wbyte(8'h11, a); check("R6", a, 0);
    tw_wbyte(8'h22, a); check("R6", a, 0);
    tw_stop;
    check("R6", stb_cnt - s0, 2);
    check("R6", last_d, 8'h22);
    tw_read(8'h20, 8'h08, d);
    check("R6", d, 8'h22);
  endtask

  task automatic t_out_of_range;
    logic [7:0] d; int s0 = stb_cnt;
    tw_write(8'h20, 8'd60, 8'h3C, "R8");
    check("R8", stb_cnt - s0, 0);
    tw_read(8'h20, 8'd60, d);
    check("R8", d, 8'h00);
    tw_write(8'h20, 8'd52, 8'h6B, "R8");
    check("R8", stb_cnt - s0, 1);
    check("R8", last_a, 8'd52);
  endtask

  task automatic t_stop_abort;
    logic a; logic [7:0] d; int s0 = stb_cnt;
    tw_start;
    tw_wbyte(8'h20, a); tw_wbyte(8'h07, a);
    for (int i = 7; i >= 4; i--) begin
      m_sda = i[0]; hw(W); m_scl = 1'b1; hw(W); m_scl = 1'b0;
    end
    tw_stop;
    check("R9", stb_cnt - s0, 0);
    check("R9", pull_low, 0);
    tw_write(8'h20, 8'h07, 8'h5A, "R9");
    tw_read(8'h20, 8'h07, d);
    check("R9", d, 8'h5A);
  endtask

  task automatic t_ad0_high;
    logic a; int s0 = stb_cnt;
    tw_write(8'h22, 8'h09, 8'h81, "R5");
    check("R5", stb_cnt - s0, 1);
    tw_start;
    tw_wbyte(8'h20, a); check("R5", a, 1);
    tw_stop;
  endtask

  task automatic t_spi_write;
    logic a; int s0 = stb_cnt;
    spi_send({8'h00, 8'h20, 8'h0C, 8'h77}, 24);
    check("R3", stb_cnt - s0, 1);
    check("R3", last_a, 8'h0C);
    check("R3", last_d, 8'h77);
    tw_start;
    tw_wbyte(8'h22, a); check("R2", a, 1);
    tw_stop;
    check("R2", pull_low, 0);
    check("R2", stb_cnt - s0, 1);
  endtask

  task automatic t_spi_ignore;
    int s0 = stb_cnt;
    spi_send({8'h00, 8'h22, 8'h05, 8'hEE}, 24);
    check("R4", stb_cnt - s0, 0);
    spi_send({8'h00, 8'h21, 8'h05, 8'hEE}, 24);
    check("R4", stb_cnt - s0, 0);
    spi_send({8'h20, 8'h0D, 8'h44, 8'h99}, 32);
    check("R4", stb_cnt - s0, 1);
    check("R4", last_a, 8'h0D);
    check("R4", last_d, 8'h44);
    spi_send({8'h00, 8'h20, 8'h40, 8'h12}, 24);
    check("R8", stb_cnt - s0, 1);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    tw_read(8'h22, 8'h0C, d); check("R3", d, 8'h77);
    tw_read(8'h22, 8'h05, d); check("R4", d, 8'hA5);
    tw_read(8'h22, 8'h0D, d); check("R4", d, 8'h44);
  endtask

  initial begin
    do_reset(1'b0);
    t_twi_write;
    t_twi_read;
    t_twi_bad_dev;
    t_twi_multi;
    t_out_of_range;
    t_stop_abort;
    do_reset(1'b1);
    t_ad0_high;
    t_spi_write;
    t_spi_ignore;
    do_reset(1'b1);
    t_readback;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule